// File: doc/BRIEF.md
# Multichannel Threshold-Controlled Packet Buffer

This block keeps the fill-level bookkeeping for a large set of logical channels, separately for the transmit and receive directions, and decides for each channel when a DMA engine should be asked to move data. The words themselves sit in a shared memory outside the block. Only the strobes that move them pass through here: a channel number, a strobe and a frame-end flag for each of the four movements (DMA fills transmit, line drains transmit, line fills receive, DMA drains receive).

On the transmit side every channel has two levels of its own. A forwarding level decides when the line side may start draining. A refill level decides when the DMA must top the channel up. On the receive side every channel has a burst level that sets how much data makes a DMA transfer worthwhile. One minimum frame length is shared by all receive channels. A received frame that ends before reaching this length is released without ever being offered to the DMA. Reading from an empty transmit channel in the middle of a frame raises a one-cycle underrun pulse on that channel's line.

Top module: `mchan_thr_buf`

## Requirements
- R1: After reset every channel is empty: the levels read 0, all start and receive request lines are low, no underrun pulse is present, and every refill request is high (default refill level 8, default start level 16, default burst level 16, default minimum frame length 4).
- R2: A transmit write adds one word and a successful transmit read removes one, both in the same cycle if both occur. `tx_level_o` shows the level of channel `tx_wr_ch_i`. A write to a channel holding DEPTH words is ignored.
- R3: `tx_go_o[c]` is high when channel c holds at least its forwarding level.
- R4: `tx_go_o[c]` is also high while a complete frame (a word written with the end flag) is buffered, and while a frame is being drained (a read without end flag was taken and no read with end flag has followed yet).
- R5: `tx_refill_o[c]` is high exactly when the level of channel c is below its refill level.
- R6: A transmit read of an empty channel in the middle of a frame pulses `tx_urun_o[c]` for one cycle. A read of an empty channel outside a frame changes nothing.
- R7: `rx_req_o[c]` is high when the words available to the DMA reach the channel's burst level (and at least one word is available).
- R8: `rx_req_o[c]` is also high whenever a complete, accepted frame is buffered, whatever the burst level.
- R9: A receive frame whose total length including the end word is below the minimum length is dropped at its end word. Its words are freed, and no request or available word results. A frame of exactly the minimum length is kept.
- R10: Words of an open receive frame shorter than the minimum length are not counted in `rx_avail_o` (the available count of channel `rx_rd_ch_i`). They are counted once the open frame reaches that length.
- R11: A configuration write with `cfg_sel_i` 0, 1 or 2 sets the forwarding, refill or burst level of channel `cfg_ch_i` only. Code 3 sets the shared minimum frame length.
- R12: Every strobe affects only the channel it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Selects the level written (0 fwd, 1 refill, 2 burst, 3 min length) |
| cfg_ch_i | input | CH_W | Channel addressed by the configuration write |
| cfg_val_i | input | CNT_W | Value written |
| tx_wr_i | input | 1 | DMA has put one word into a transmit channel |
| tx_wr_ch_i | input | CH_W | Channel of that write; also selects `tx_level_o` |
| tx_wr_eof_i | input | 1 | The written word ends a frame |
| tx_rd_i | input | 1 | Line side takes one word from a transmit channel |
| tx_rd_ch_i | input | CH_W | Channel of that read |
| tx_rd_eof_i | input | 1 | The word taken ends a frame |
| rx_wr_i | input | 1 | Line side puts one received word into a channel |
| rx_wr_ch_i | input | CH_W | Channel of that write |
| rx_wr_eof_i | input | 1 | The received word ends a frame |
| rx_rd_i | input | 1 | DMA takes one word from a receive channel |
| rx_rd_ch_i | input | CH_W | Channel of that read; also selects `rx_avail_o` |
| rx_rd_eof_i | input | 1 | The word taken ends a frame |
| tx_level_o | output | CNT_W | Transmit level of channel `tx_wr_ch_i` |
| rx_avail_o | output | CNT_W | Receive words available to the DMA on channel `rx_rd_ch_i` |
| tx_go_o | output | N_CH | Per-channel permission to start draining |
| tx_refill_o | output | N_CH | Per-channel refill request |
| tx_urun_o | output | N_CH | Per-channel one-cycle underrun pulse |
| rx_req_o | output | N_CH | Per-channel receive transfer request |

## Verification
The hardest case to reach is a runt that must be told apart from a frame of exactly the minimum length. Both have words held back while they are open, and only the end word decides whether those words vanish or become available. The stimulus first ends a short frame on one channel, then builds a frame of exactly the minimum length on the same channel. The available count must show only the second frame's words, which shows that the runt's words were freed. The transmit underrun needs a channel drained to empty in the middle of a frame, so the vector table walks one channel through two frames and then reads past the end of a third, unterminated one.

// File: rtl/mchan_pkg.sv
package mchan_pkg;
  typedef enum logic [1:0] {
    CFG_TX_FWD    = 2'd0,
    CFG_TX_REFILL = 2'd1,
    CFG_RX_BURST  = 2'd2,
    CFG_RX_MINLEN = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/mchan_tx_ctl.sv
module mchan_tx_ctl #(
  parameter int DEPTH      = 64,
  parameter int CNT_W      = 7,
  parameter int DEF_FWD    = 16,
  parameter int DEF_REFILL = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_fwd_we_i,
  input  logic             cfg_refill_we_i,
  input  logic [CNT_W-1:0] cfg_val_i,
  input  logic             wr_i,
  input  logic             wr_eof_i,
  input  logic             rd_i,
  input  logic             rd_eof_i,
  output logic [CNT_W-1:0] level_o,
  output logic             go_o,
  output logic             refill_o,
  output logic             urun_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fill_q, frames_q, fwd_q, refill_q;
  logic             mid_q, urun_q;
  logic             wr_ok, rd_ok, fr_inc, fr_dec;

  assign wr_ok  = wr_i && (fill_q != FULL);
  assign rd_ok  = rd_i && (fill_q != '0);
  assign fr_inc = wr_ok && wr_eof_i;
  assign fr_dec = rd_ok && rd_eof_i && (frames_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= '0;
      frames_q <= '0;
      fwd_q    <= CNT_W'(DEF_FWD);
      refill_q <= CNT_W'(DEF_REFILL);
      mid_q    <= 1'b0;
      urun_q   <= 1'b0;
    end else begin
      fill_q   <= fill_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
      frames_q <= frames_q + CNT_W'(fr_inc) - CNT_W'(fr_dec);
      if (cfg_fwd_we_i)    fwd_q    <= cfg_val_i;
      if (cfg_refill_we_i) refill_q <= cfg_val_i;
      if (rd_ok)           mid_q    <= !rd_eof_i;
      // empty read inside a frame starves the line
      urun_q <= rd_i && (fill_q == '0) && mid_q;
    end
  end

  assign level_o  = fill_q;
  assign go_o     = mid_q || (fill_q >= fwd_q) || (frames_q != '0);
  assign refill_o = fill_q < refill_q;
  assign urun_o   = urun_q;
endmodule

// File: rtl/mchan_rx_ctl.sv
module mchan_rx_ctl #(
  parameter int DEPTH     = 64,
  parameter int CNT_W     = 7,
  parameter int DEF_BURST = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_burst_we_i,
  input  logic [CNT_W-1:0] cfg_val_i,
  input  logic [CNT_W-1:0] min_len_i,
  input  logic             wr_i,
  input  logic             wr_eof_i,
  input  logic             rd_i,
  input  logic             rd_eof_i,
  output logic [CNT_W-1:0] avail_o,
  output logic             req_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fill_q, open_q, frames_q, burst_q;
  logic [CNT_W-1:0] fill_d, open_d, frames_d;
  logic [CNT_W-1:0] held, avail;
  logic             wr_ok, rd_ok, runt;

  // open frame below minimum is withheld from the DMA
  assign held  = (open_q < min_len_i) ? open_q : '0;
  assign avail = fill_q - held;
  assign wr_ok = wr_i && (fill_q != FULL);
  assign rd_ok = rd_i && (avail != '0);
  assign runt  = ({1'b0, open_q} + 1'b1) < {1'b0, min_len_i};

  always_comb begin
    fill_d   = fill_q;
    open_d   = open_q;
    frames_d = frames_q;
    if (wr_ok) begin
      if (wr_eof_i) begin
        open_d = '0;
        if (runt) begin
          fill_d = fill_q - open_q;
        end else begin
          fill_d   = fill_q + 1'b1;
          frames_d = frames_q + 1'b1;
        end
      end else begin
        fill_d = fill_q + 1'b1;
        if (open_q != '1) open_d = open_q + 1'b1;
      end
    end
    if (rd_ok) begin
      fill_d = fill_d - 1'b1;
      if (rd_eof_i && (frames_d != '0)) frames_d = frames_d - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= '0;
      open_q   <= '0;
      frames_q <= '0;
      burst_q  <= CNT_W'(DEF_BURST);
    end else begin
      fill_q   <= fill_d;
      open_q   <= open_d;
      frames_q <= frames_d;
      if (cfg_burst_we_i) burst_q <= cfg_val_i;
    end
  end

  assign avail_o = avail;
  assign req_o   = (avail != '0) && ((avail >= burst_q) || (frames_q != '0));
endmodule

// File: rtl/mchan_thr_buf.sv
module mchan_thr_buf #(
  parameter int N_CH       = 256,
  parameter int DEPTH      = 64,
  parameter int DEF_FWD    = 16,
  parameter int DEF_REFILL = 8,
  parameter int DEF_BURST  = 16,
  parameter int DEF_MIN    = 4,
  localparam int CH_W      = $clog2(N_CH),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [CH_W-1:0]  cfg_ch_i,
  input  logic [CNT_W-1:0] cfg_val_i,
  input  logic             tx_wr_i,
  input  logic [CH_W-1:0]  tx_wr_ch_i,
  input  logic             tx_wr_eof_i,
  input  logic             tx_rd_i,
  input  logic [CH_W-1:0]  tx_rd_ch_i,
  input  logic             tx_rd_eof_i,
  input  logic             rx_wr_i,
  input  logic [CH_W-1:0]  rx_wr_ch_i,
  input  logic             rx_wr_eof_i,
  input  logic             rx_rd_i,
  input  logic [CH_W-1:0]  rx_rd_ch_i,
  input  logic             rx_rd_eof_i,
  output logic [CNT_W-1:0] tx_level_o,
  output logic [CNT_W-1:0] rx_avail_o,
  output logic [N_CH-1:0]  tx_go_o,
  output logic [N_CH-1:0]  tx_refill_o,
  output logic [N_CH-1:0]  tx_urun_o,
  output logic [N_CH-1:0]  rx_req_o
);
  import mchan_pkg::*;

  cfg_sel_e         sel;
  logic [CNT_W-1:0] min_len_q;
  logic [CNT_W-1:0] tx_level [N_CH];
  logic [CNT_W-1:0] rx_avail [N_CH];

  assign sel = cfg_sel_e'(cfg_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                min_len_q <= CNT_W'(DEF_MIN);
    else if (cfg_we_i && sel == CFG_RX_MINLEN) min_len_q <= cfg_val_i;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic cfg_hit;
    assign cfg_hit = cfg_we_i && (cfg_ch_i == CH_W'(c));

    mchan_tx_ctl #(
      .DEPTH(DEPTH), .CNT_W(CNT_W), .DEF_FWD(DEF_FWD), .DEF_REFILL(DEF_REFILL)
    ) u_tx (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .cfg_fwd_we_i   (cfg_hit && sel == CFG_TX_FWD),
      .cfg_refill_we_i(cfg_hit && sel == CFG_TX_REFILL),
      .cfg_val_i      (cfg_val_i),
      .wr_i           (tx_wr_i && tx_wr_ch_i == CH_W'(c)),
      .wr_eof_i       (tx_wr_eof_i),
      .rd_i           (tx_rd_i && tx_rd_ch_i == CH_W'(c)),
      .rd_eof_i       (tx_rd_eof_i),
      .level_o        (tx_level[c]),
      .go_o           (tx_go_o[c]),
      .refill_o       (tx_refill_o[c]),
      .urun_o         (tx_urun_o[c])
    );

    mchan_rx_ctl #(
      .DEPTH(DEPTH), .CNT_W(CNT_W), .DEF_BURST(DEF_BURST)
    ) u_rx (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .cfg_burst_we_i(cfg_hit && sel == CFG_RX_BURST),
      .cfg_val_i     (cfg_val_i),
      .min_len_i     (min_len_q),
      .wr_i          (rx_wr_i && rx_wr_ch_i == CH_W'(c)),
      .wr_eof_i      (rx_wr_eof_i),
      .rd_i          (rx_rd_i && rx_rd_ch_i == CH_W'(c)),
      .rd_eof_i      (rx_rd_eof_i),
      .avail_o       (rx_avail[c]),
      .req_o         (rx_req_o[c])
    );
  end

  assign tx_level_o = tx_level[tx_wr_ch_i];
  assign rx_avail_o = rx_avail[rx_rd_ch_i];
endmodule

// File: rtl/mchan_thr_buf_chk.sv
module mchan_thr_buf_chk #(
  parameter int N_CH  = 256,
  parameter int DEPTH = 64,
  localparam int CH_W  = $clog2(N_CH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_wr_i,
  input logic             tx_rd_i,
  input logic [CH_W-1:0]  tx_wr_ch_i,
  input logic [CH_W-1:0]  rx_rd_ch_i,
  input logic [CNT_W-1:0] tx_level_o,
  input logic [CNT_W-1:0] rx_avail_o,
  input logic [N_CH-1:0]  tx_urun_o,
  input logic [N_CH-1:0]  rx_req_o
);
  a_r2_level_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level_o <= CNT_W'(DEPTH));

  a_r2_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_wr_i && !tx_rd_i) |=> (!$stable(tx_wr_ch_i) || $stable(tx_level_o)));

  a_r6_urun_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_urun_o));

  a_r6_urun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_urun_o) |-> $past(tx_rd_i));

  a_r7_req_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_req_o[rx_rd_ch_i] |-> (rx_avail_o != '0));
endmodule

bind mchan_thr_buf mchan_thr_buf_chk #(.N_CH(N_CH), .DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_wr_i   (tx_wr_i),
  .tx_rd_i   (tx_rd_i),
  .tx_wr_ch_i(tx_wr_ch_i),
  .rx_rd_ch_i(rx_rd_ch_i),
  .tx_level_o(tx_level_o),
  .rx_avail_o(rx_avail_o),
  .tx_urun_o (tx_urun_o),
  .rx_req_o  (rx_req_o)
);

// File: tb/tb_mchan_thr_buf.sv
module tb_mchan_thr_buf;
  localparam int N_CH  = 256;
  localparam int DEPTH = 64;
  localparam int CH_W  = $clog2(N_CH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_sel = '0;
  logic [CH_W-1:0]  cfg_ch = '0;
  logic [CNT_W-1:0] cfg_val = '0;
  logic             tx_wr = 1'b0, tx_wr_eof = 1'b0, tx_rd = 1'b0, tx_rd_eof = 1'b0;
  logic [CH_W-1:0]  tx_wr_ch = '0, tx_rd_ch = '0;
  logic             rx_wr = 1'b0, rx_wr_eof = 1'b0, rx_rd = 1'b0, rx_rd_eof = 1'b0;
  logic [CH_W-1:0]  rx_wr_ch = '0, rx_rd_ch = '0;
  logic [CNT_W-1:0] tx_level, rx_avail;
  logic [N_CH-1:0]  tx_go, tx_refill, tx_urun, rx_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mchan_thr_buf dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_ch_i(cfg_ch), .cfg_val_i(cfg_val),
    .tx_wr_i(tx_wr), .tx_wr_ch_i(tx_wr_ch), .tx_wr_eof_i(tx_wr_eof),
    .tx_rd_i(tx_rd), .tx_rd_ch_i(tx_rd_ch), .tx_rd_eof_i(tx_rd_eof),
    .rx_wr_i(rx_wr), .rx_wr_ch_i(rx_wr_ch), .rx_wr_eof_i(rx_wr_eof),
    .rx_rd_i(rx_rd), .rx_rd_ch_i(rx_rd_ch), .rx_rd_eof_i(rx_rd_eof),
    .tx_level_o(tx_level), .rx_avail_o(rx_avail),
    .tx_go_o(tx_go), .tx_refill_o(tx_refill), .tx_urun_o(tx_urun), .rx_req_o(rx_req)
  );

  // {wr, rd, eof, level[2:0], go, refill, urun} on channel 5 (fwd 4, refill 3)
  localparam logic [8:0] TX_VEC [13] = '{
    9'b100_001_010, 9'b100_010_010, 9'b100_011_000, 9'b101_100_100,
    9'b010_011_100, 9'b011_010_010, 9'b101_011_100, 9'b010_010_110,
    9'b010_001_110, 9'b011_000_010, 9'b110_001_010, 9'b010_000_110,
    9'b010_000_111
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; tx_wr = 1'b0; tx_rd = 1'b0; rx_wr = 1'b0; rx_rd = 1'b0;
    tx_wr_eof = 1'b0; tx_rd_eof = 1'b0; rx_wr_eof = 1'b0; rx_rd_eof = 1'b0;
  endtask

  task automatic cfg(input int sel, input int ch, input int val);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_ch = CH_W'(ch); cfg_val = CNT_W'(val);
    step();
  endtask

  task automatic txw(input int ch, input bit eof);
    tx_wr = 1'b1; tx_wr_ch = CH_W'(ch); tx_wr_eof = eof;
    step();
  endtask

  task automatic rxw(input int ch, input bit eof);
    rx_wr = 1'b1; rx_wr_ch = CH_W'(ch); rx_wr_eof = eof;
    step();
  endtask

  task automatic rxr(input int ch, input bit eof);
    rx_rd = 1'b1; rx_rd_ch = CH_W'(ch); rx_rd_eof = eof;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(tx_level == 0, "R1 tx level", int'(tx_level), 0);
    chk(rx_avail == 0, "R1 rx avail", int'(rx_avail), 0);
    chk(tx_go == '0 && rx_req == '0 && tx_urun == '0, "R1 outputs low",
        int'($countones(tx_go) + $countones(rx_req) + $countones(tx_urun)), 0);
    chk(&tx_refill, "R1 refill all high", int'($countones(tx_refill)), N_CH);

    // R11 per-channel tx levels on channel 5
    cfg(0, 5, 4);
    cfg(1, 5, 3);

    // R2 R3 R4 R5 R6 vector walk
    for (int i = 0; i < 13; i++) begin
      logic [8:0] v;
      v = TX_VEC[i];
      tx_wr = v[8]; tx_rd = v[7]; tx_wr_eof = v[6]; tx_rd_eof = v[6];
      tx_wr_ch = CH_W'(5); tx_rd_ch = CH_W'(5);
      step();
      chk({tx_level[2:0], tx_go[5], tx_refill[5], tx_urun[5]} == v[5:0],
          $sformatf("R2/R3/R4/R5/R6 vector %0d", i),
          int'({tx_level[2:0], tx_go[5], tx_refill[5], tx_urun[5]}), int'(v[5:0]));
    end
    // R6 pulse lasts one cycle
    step();
    chk(tx_urun[5] == 1'b0, "R6 pulse ends", int'(tx_urun[5]), 0);

    // R11 R12 channel 6 keeps default levels
    for (int i = 0; i < 4; i++) txw(6, 1'b0);
    chk(tx_go[6] == 1'b0, "R11 ch6 default fwd", int'(tx_go[6]), 0);
    chk(tx_refill[6] == 1'b1, "R11 ch6 default refill", int'(tx_refill[6]), 1);
    tx_wr_ch = CH_W'(5);
    @(negedge clk);
    chk(tx_level == 0, "R12 ch5 untouched", int'(tx_level), 0);

    // R3 default forwarding level, R2 full
    for (int i = 0; i < 15; i++) txw(9, 1'b0);
    chk(tx_go[9] == 1'b0, "R3 below fwd", int'(tx_go[9]), 0);
    txw(9, 1'b0);
    chk(tx_go[9] == 1'b1, "R3 at fwd", int'(tx_go[9]), 1);
    chk(tx_refill[9] == 1'b0, "R5 above refill", int'(tx_refill[9]), 0);
    for (int i = 0; i < 48; i++) txw(9, 1'b0);
    chk(tx_level == DEPTH, "R2 full", int'(tx_level), DEPTH);
    txw(9, 1'b0);
    chk(tx_level == DEPTH, "R2 write to full ignored", int'(tx_level), DEPTH);

    // R7 R10 R8 receive burst on channel 20 (burst 3, min 4)
    cfg(2, 20, 3);
    rx_rd_ch = CH_W'(20);
    for (int i = 0; i < 3; i++) rxw(20, 1'b0);
    chk(rx_avail == 0 && !rx_req[20], "R10 open frame held", int'(rx_avail), 0);
    rxw(20, 1'b0);
    chk(rx_avail == 4, "R10 released at min", int'(rx_avail), 4);
    chk(rx_req[20] == 1'b1, "R7 burst reached", int'(rx_req[20]), 1);
    for (int i = 0; i < 4; i++) rxr(20, 1'b0);
    chk(rx_avail == 0 && !rx_req[20], "R7 drained", int'(rx_avail), 0);
    rxw(20, 1'b1);
    chk(rx_avail == 1 && rx_req[20], "R8 request on frame end", int'(rx_req[20]), 1);
    rxr(20, 1'b1);
    chk(!rx_req[20], "R8 request cleared", int'(rx_req[20]), 0);

    // R9 runt on channel 21, then frame of exactly minimum length
    rx_rd_ch = CH_W'(21);
    rxw(21, 1'b0); rxw(21, 1'b0); rxw(21, 1'b1);
    chk(rx_avail == 0 && !rx_req[21], "R9 runt dropped", int'(rx_avail), 0);
    rxw(21, 1'b0); rxw(21, 1'b0); rxw(21, 1'b0); rxw(21, 1'b1);
    chk(rx_avail == 4, "R9 runt words freed, min frame kept", int'(rx_avail), 4);
    chk(rx_req[21] == 1'b1, "R9 min frame requested", int'(rx_req[21]), 1);

    // R11 shared minimum length, R12 isolation
    cfg(3, 0, 2);
    rx_rd_ch = CH_W'(22);
    rxw(22, 1'b1);
    chk(rx_avail == 0 && !rx_req[22], "R11 new min drops 1-word frame", int'(rx_avail), 0);
    rxw(22, 1'b0); rxw(22, 1'b1);
    chk(rx_avail == 2 && rx_req[22], "R11 2-word frame kept", int'(rx_avail), 2);
    rxw(23, 1'b0); rxw(23, 1'b0);
    chk(rx_avail == 2, "R12 ch22 unaffected", int'(rx_avail), 2);
    chk(rx_req[23] == 1'b0, "R7 below burst no request", int'(rx_req[23]), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule